// File: doc/BRIEF.md
# Converter Serial Port and Power-Down Command Controller

This block is the digital side of a differential serial sampling converter. A rising edge on the convert strobe captures the parallel sample word and starts a result frame. Each rising edge of the external serial clock then shifts one bit of that frame onto the serial data line. The frame carries the result of the conversion started by the convert strobe before the current one. It is 16 bits long, MSB first: two zero bits, then the 14-bit two's-complement word. The output enable is low whenever no frame is in progress, so the pad driver can go high-impedance.

The same two pins also carry power-down commands. The controller counts convert pulses that arrive with the serial clock frozen at either level. Any serial clock transition clears that count. Two such pulses put the block into nap mode, and four or more put it into sleep mode. The next serial clock edge of either polarity brings the block back to active. While napping or sleeping, convert pulses capture nothing and the data line stays disabled. All inputs are synchronized to a system clock, and every action is taken in that domain.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset, `sdo_oe_o` is 0, `sdo_o` is 0 and `pwr_mode_o` is 0 (active). The held result is 0.
- R2: A captured convert rising edge raises `sdo_oe_o`. The first two frame bits are 0.
- R3: Frame bits come out MSB first, one per serial clock rising edge. Serial clock falling edges do not advance the frame.
- R4: Data bits 13..0 of a frame equal `sample_i` as captured at the convert edge before the one that started the frame, passed through unchanged as two's complement. The first frame after reset carries 0.
- R5: `sdo_o` is 0 whenever `sdo_oe_o` is 0. `sdo_oe_o` falls on the 16th serial clock rising edge of a frame.
- R6: A second convert pulse with no serial clock edge since the previous convert pulse sets `pwr_mode_o` to 1 (nap). It drops any frame in progress.
- R7: A third such pulse leaves the mode at nap. The fourth and later pulses set `pwr_mode_o` to 2 (sleep). Code 3 never appears.
- R8: Any serial clock edge, rising or falling, returns `pwr_mode_o` to 0 and clears the convert pulse count.
- R9: In nap or sleep, convert pulses neither capture `sample_i` nor start a frame. The held result survives until the next captured conversion.
- R10: A convert pulse after a frame has been clocked out is counted as the first pulse, so it never enters nap.
- R11: Power-down commands behave the same with the serial clock held high as with it held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Convert start strobe, asynchronous |
| sck_i | input | 1 | External serial clock, asynchronous |
| sample_i | input | DATA_W | Quantized sample, two's complement |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable, drives the pad's three-state control |
| pwr_mode_o | output | 2 | Power state: 0 active, 1 nap, 2 sleep |

## Verification
The hardest case to reach is a power-down command arriving after a conversion has already started. The first convert pulse of a command always captures a sample and opens a frame. The second pulse must then tear that frame down before any serial clock edge arrives. The stimulus issues a conversion, sends further convert pulses with the serial clock frozen low, and repeats this with the clock frozen high. It then wakes the block with a single edge, once rising and once falling. The next full frame must carry the value captured before power-down, not the values presented during the ignored pulses.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prv_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], d_i};
  end

  assign lvl_o = chain_q[STAGES-1];
  assign prv_o = chain_q[STAGES];
endmodule

// File: rtl/adc_pwr_cmd.sv
module adc_pwr_cmd
  import adc_ser_pkg::*;
#(
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      conv_rise_i,
  input  logic      sck_act_i,
  output pwr_mode_e mode_o,
  output logic      capture_o,
  output logic      pdn_o
);
  localparam int CNT_W = $clog2(SLEEP_PULSES + 1);

  pwr_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = (cnt_q == CNT_W'(SLEEP_PULSES)) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (sck_act_i) begin
      // clock activity wakes; a coincident convert is the first of a new run
      cnt_d  = conv_rise_i ? CNT_W'(1) : '0;
      mode_d = PWR_ACTIVE;
    end else if (conv_rise_i) begin
      cnt_d = cnt_inc;
      if (int'(cnt_inc) >= SLEEP_PULSES)
        mode_d = PWR_SLEEP;
      else if (int'(cnt_inc) >= NAP_PULSES && mode_q == PWR_ACTIVE)
        mode_d = PWR_NAP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= PWR_ACTIVE;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign capture_o = conv_rise_i & (sck_act_i | (mode_q == PWR_ACTIVE && cnt_q == '0));
  assign pdn_o     = conv_rise_i & ~sck_act_i & (mode_d != PWR_ACTIVE);
  assign mode_o    = mode_q;
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int DATA_W = 14,
  parameter int LEAD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int FRAME_W = LEAD_W + DATA_W;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sreg_q;
  logic [LEFT_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (abort_i) begin
      left_q <= '0;
    end else if (load_i) begin
      sreg_q <= {{LEAD_W{1'b0}}, data_i};
      left_q <= LEFT_W'(FRAME_W);
    end else if (adv_i && left_q != '0) begin
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign oe_o  = (left_q != '0);
  assign sdo_o = oe_o & sreg_q[FRAME_W-1];
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_ser_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int LEAD_W       = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [1:0]        pwr_mode_o
);
  logic conv_lvl, conv_prv, sck_lvl, sck_prv;
  logic conv_rise, sck_rise, sck_act;
  logic capture, pdn;
  pwr_mode_e mode;
  logic [DATA_W-1:0] held_q;

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_conv_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(conv_i), .lvl_o(conv_lvl), .prv_o(conv_prv)
  );
  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .lvl_o(sck_lvl), .prv_o(sck_prv)
  );

  assign conv_rise = conv_lvl & ~conv_prv;
  assign sck_rise  = sck_lvl & ~sck_prv;
  assign sck_act   = sck_lvl ^ sck_prv;

  adc_pwr_cmd #(.NAP_PULSES(NAP_PULSES), .SLEEP_PULSES(SLEEP_PULSES)) u_pwr (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_rise_i(conv_rise), .sck_act_i(sck_act),
    .mode_o(mode), .capture_o(capture), .pdn_o(pdn)
  );

  // result of the current conversion, sent with the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= '0;
    else if (capture) held_q <= sample_i;
  end

  adc_frame_shift #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(capture), .adv_i(sck_rise),
    .abort_i(pdn), .data_i(held_q), .sdo_o(sdo_o), .oe_o(sdo_oe_o)
  );

  assign pwr_mode_o = mode;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_act_i,
  input logic       capture_i,
  input logic       pdn_i,
  input logic       sdo_i,
  input logic       sdo_oe_i,
  input logic [1:0] mode_i
);
  p_frame_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (sdo_oe_i && !sdo_i));

  p_hold_between_edges_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_i && !sck_act_i && !capture_i && !pdn_i) |=> (sdo_oe_i && $stable(sdo_i)));

  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_i |-> !sdo_i);

  p_mode_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 2'd3);

  p_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_act_i |=> (mode_i == 2'd0));

  p_no_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0 && !sck_act_i) |-> !capture_i);

  p_lowpower_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0) |-> !sdo_oe_i);
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_act_i(sck_act), .capture_i(capture),
  .pdn_i(pdn), .sdo_i(sdo_o), .sdo_oe_i(sdo_oe_o), .mode_i(pwr_mode_o)
);

// File: tb/adc_serial_ctrl_bench.sv
module adc_serial_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 14;
  localparam int FRAME_W    = 16;
  localparam int SETTLE     = 5;
  localparam int HALF       = 8;

  typedef struct packed {
    logic [DATA_W-1:0] word;
    logic              may_abort;
  } exp_t;

  logic clk, rst_n, conv, sck;
  logic [DATA_W-1:0] sample;
  logic sdo, sdo_oe;
  logic [1:0] mode;

  exp_t exp_q[$];
  logic [DATA_W-1:0] held_m;
  int checks = 0;
  int fails  = 0;

  adc_serial_ctrl u_adc_serial_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .sck_i(sck), .sample_i(sample),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .pwr_mode_o(mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck = 1'b1; wait_clk(HALF);
    sck = 1'b0; wait_clk(HALF);
  endtask

  task automatic conv_pulse();
    conv = 1'b1; wait_clk(4);
    conv = 1'b0; wait_clk(4);
  endtask

  // driver: predicts the frame this conversion will open, then fires it
  task automatic do_conv(input logic [DATA_W-1:0] val, input logic may_abort);
    exp_q.push_back(exp_t'{word: held_m, may_abort: may_abort});
    sample = val;
    held_m = val;
    conv_pulse();
    sample = ~val;
  endtask

  task automatic read_frame();
    repeat (FRAME_W) sck_pulse();
    wait_clk(2);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: assembles each frame and compares against the queue
  initial begin
    forever begin
      logic [FRAME_W-1:0] got;
      bit aborted;
      exp_t e;
      @(posedge sdo_oe);
      @(negedge clk);
      got = '0;
      aborted = 1'b0;
      got[FRAME_W-1] = sdo;
      for (int k = FRAME_W - 2; k >= 0; k--) begin
        @(posedge sck or negedge sdo_oe);
        if (!sdo_oe) begin
          aborted = 1'b1;
          break;
        end
        wait_clk(SETTLE);
        got[k] = sdo;
      end
      if (!aborted) begin
        @(posedge sck);
        wait_clk(SETTLE);
        chk(!sdo_oe && !sdo, "R5 enable after 16th edge", int'(sdo_oe), 0);
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected frame", int'(got), 0);
      end else begin
        e = exp_q.pop_front();
        if (aborted) begin
          chk(e.may_abort == 1'b1, "R6 frame dropped", 1, int'(e.may_abort));
        end else begin
          chk(got[FRAME_W-1 -: 2] == 2'b00, "R2 leading bits", int'(got[FRAME_W-1 -: 2]), 0);
          chk(got[DATA_W-1:0] == e.word, "R3 R4 frame word", int'(got[DATA_W-1:0]), int'(e.word));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0; conv = 1'b0; sck = 1'b0; sample = '0; held_m = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    chk(sdo_oe == 1'b0, "R1 enable", int'(sdo_oe), 0);
    chk(sdo == 1'b0, "R1 data", int'(sdo), 0);
    chk(mode == 2'd0, "R1 mode", int'(mode), 0);

    // normal conversions, first frame carries the reset value
    do_conv(14'h1234, 1'b0);
    read_frame();
    do_conv(14'h2000, 1'b0);
    wait_clk(2);
    chk(mode == 2'd0, "R10 convert after frame stays active", int'(mode), 0);
    read_frame();
    do_conv(14'h1FFF, 1'b0);
    read_frame();

    // power-down with clock frozen low
    do_conv(14'h0ABC, 1'b1);
    conv_pulse();
    chk(mode == 2'd1, "R6 nap entered", int'(mode), 1);
    chk(sdo_oe == 1'b0, "R6 frame dropped", int'(sdo_oe), 0);
    conv_pulse();
    chk(mode == 2'd1, "R7 third pulse stays nap", int'(mode), 1);
    conv_pulse();
    chk(mode == 2'd2, "R7 sleep entered", int'(mode), 2);
    conv_pulse();
    chk(mode == 2'd2, "R7 stays sleep", int'(mode), 2);
    chk(sdo_oe == 1'b0, "R9 no frame in sleep", int'(sdo_oe), 0);
    sck_pulse();
    chk(mode == 2'd0, "R8 wake on clock pulse", int'(mode), 0);
    chk(sdo_oe == 1'b0, "R9 no frame after wake", int'(sdo_oe), 0);
    do_conv(14'h0001, 1'b0);
    read_frame();

    // power-down with clock frozen high, woken by a falling edge
    sck = 1'b1;
    wait_clk(HALF);
    do_conv(14'h3FFF, 1'b1);
    conv_pulse();
    chk(mode == 2'd1, "R11 nap with clock high", int'(mode), 1);
    conv_pulse();
    conv_pulse();
    chk(mode == 2'd2, "R11 sleep with clock high", int'(mode), 2);
    sck = 1'b0;
    wait_clk(HALF);
    chk(mode == 2'd0, "R8 wake on falling edge", int'(mode), 0);
    do_conv(14'h2AAA, 1'b0);
    read_frame();

    wait_clk(20);
    chk(exp_q.size() == 0, "R4 all predicted frames seen", exp_q.size(), 0);
    report();
  end
endmodule